// File: doc/BRIEF.md
# Secure Mode Exit Sequencer

This block handles the exit from a privileged, authenticated-code execution mode. When software requests the exit operation, the block looks at the operation selector, the parameter and target registers, the operand size, the privilege level, the processor mode flags and the code segment limit. It tests the fault conditions in a strict priority order. The first condition that holds ends the request with a one-hot fault report. If no condition holds, the block runs a fixed sequence of cleanup steps and then commits a new instruction pointer.

Each cleanup step is a one-cycle request strobe on its own line. The step is complete when the matching acknowledge arrives. The next step starts only after that. When the last step is acknowledged, the block clears its internal authenticated-mode flag. It then presents the computed jump target together with a load pulse. The flag is set by an entry pulse while the block is idle, which stands in for the entry path that lives elsewhere.

Top module: `secure_exit_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `step_req`, `ip_load`, `acm_active` and `new_ip` are all zero.
- R2: `start` is taken only while the block is idle. `busy` is high from the cycle after an accepted `start` until the cycle in which `done` is high, and `busy` is low in that cycle. A `start` while busy has no effect. `mode_enter` sets `acm_active` when idle and `start` is low.
- R3: The checks run in this priority order: undefined-opcode (`fault`=3'b001) when `sec_ext_en`=0; then virtualization exit (3'b100) when `guest_nonroot`=1; then undefined-opcode when `leaf_sel`≠3 or `leaf_avail`=0; then the protection checks.
- R4: A protection fault (3'b010) is raised by any one of these: `prot_en`=0, `cpl`≠0, `v86_mode`=1, `acm_active`=0, `in_smm`=1, `host_root`=1, or `param_reg`≠0.
- R5: When `long_mode`=1, a target whose bits 63 down to 47 are not all equal raises a protection fault. When `long_mode`=0, no such check is made.
- R6: `op_size`=2'b10 takes all 64 bits of `target_reg`, 2'b01 takes the low 32 bits, and any other value takes the low 16 bits, zero-extended. A result strictly greater than `cs_limit` raises a protection fault.
- R7: On a fault, `done` and `fault` pulse for one cycle, two cycles after the accepting edge. In that case no strobe fires, and `acm_active` and `new_ip` do not change.
- R8: On success, six one-hot single-cycle strobes fire in this order: bit 0 invalidates the private code RAM, bit 1 invalidates the TLBs, bit 2 drains outgoing messages, bit 3 closes locality 3, bit 4 locks SMRAM, and bit 5 releases the processor. The first strobe appears in the cycle after the accepting edge.
- R9: A step advances only on its own `step_ack` bit. The acknowledge may arrive in the strobe cycle or later. Acknowledges on other bits, or while the block is idle, are ignored, and a strobe is never repeated while its step waits.
- R10: In the cycle after the last acknowledge, `done` and `ip_load` are high, `fault` is zero, `new_ip` holds the computed target and `acm_active` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request the exit operation |
| mode_enter | input | 1 | Set the authenticated-mode flag while idle |
| leaf_sel | input | LEAF_W | Operation selector; the exit operation is code 3 |
| leaf_avail | input | 1 | The operation is reported as supported |
| sec_ext_en | input | 1 | Security extensions enabled |
| guest_nonroot | input | 1 | Running as a virtualized guest |
| host_root | input | 1 | Running as the virtualization host |
| prot_en | input | 1 | Protected mode enabled |
| cpl | input | 2 | Current privilege level |
| v86_mode | input | 1 | Virtual-8086 mode active |
| in_smm | input | 1 | System-management mode active |
| long_mode | input | 1 | 64-bit mode active |
| op_size | input | 2 | 00 = 16-bit, 01 = 32-bit, 10 = 64-bit |
| param_reg | input | XLEN | Parameter register; must be zero |
| target_reg | input | XLEN | Jump target register |
| cs_limit | input | XLEN | Code segment limit |
| step_ack | input | 6 | Per-step acknowledge |
| step_req | output | 6 | Per-step request strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 3 | One-hot outcome: bit 0 undefined-opcode, bit 1 protection, bit 2 virtualization exit |
| ip_load | output | 1 | New instruction pointer is valid |
| new_ip | output | XLEN | Committed jump target |
| acm_active | output | 1 | Authenticated-mode flag |

## Verification
The assertions check, on every cycle, that strobes are one-hot and follow the step order. They also check that no strobe appears while idle, that any fault code is one-hot and comes with `done`, that the mode flag holds through a fault, and that `new_ip` moves only with `ip_load`. Only the bench scenarios can show which fault wins when several conditions hold at once. The same goes for the 16-, 32- and 64-bit target truncation, the canonical and segment-limit boundaries, and the ignored stray acknowledges and repeated starts, because each of these needs a chosen input pattern and a computed expected value.

// File: rtl/secure_exit_pkg.sv
package secure_exit_pkg;

   localparam int unsigned N_STEPS = 6;
   localparam int unsigned FLT_W   = 3;

   localparam logic [FLT_W-1:0] FLT_NONE   = 3'b000;
   localparam logic [FLT_W-1:0] FLT_UD     = 3'b001;
   localparam logic [FLT_W-1:0] FLT_GP     = 3'b010;
   localparam logic [FLT_W-1:0] FLT_VMEXIT = 3'b100;

   localparam logic [1:0] OPSZ_32 = 2'b01;
   localparam logic [1:0] OPSZ_64 = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_REPORT = 2'd1,
      ST_RUN    = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic sec_ext_en;
      logic guest_nonroot;
      logic host_root;
      logic prot_en;
      logic v86_mode;
      logic in_smm;
      logic long_mode;
      logic acm_flag;
   } env_t;

endpackage

// File: rtl/secure_exit_faults.sv
module secure_exit_faults
   import secure_exit_pkg::*;
#(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned VA_BITS   = 48,
   parameter int unsigned LEAF_W    = 32,
   parameter int unsigned LEAF_CODE = 3
) (
   input  logic [LEAF_W-1:0] leaf_sel,
   input  logic              leaf_avail,
   input  env_t              env,
   input  logic [1:0]        cpl,
   input  logic [1:0]        op_size,
   input  logic [XLEN-1:0]   param_reg,
   input  logic [XLEN-1:0]   target_reg,
   input  logic [XLEN-1:0]   cs_limit,
   output logic [FLT_W-1:0]  fault,
   output logic [XLEN-1:0]   target
);

   logic canon_ok;
   logic leaf_ok;
   logic gp_mode;
   logic gp_addr;

   // canonical form: bits above the virtual address width copy the top VA bit
   generate
      if (VA_BITS >= XLEN) begin : g_no_canon
         assign canon_ok = 1'b1;
      end else begin : g_canon
         localparam int unsigned HI_W = XLEN - VA_BITS + 1;
         logic [HI_W-1:0] hi_bits;
         assign hi_bits  = target_reg[XLEN-1:VA_BITS-1];
         assign canon_ok = (hi_bits == '0) || (hi_bits == '1);
      end
   endgenerate

   always_comb begin
      case (op_size)
         OPSZ_64: target = target_reg;
         OPSZ_32: target = XLEN'(target_reg[31:0]);
         default: target = XLEN'(target_reg[15:0]);
      endcase
   end

   assign leaf_ok = leaf_avail && (leaf_sel == LEAF_W'(LEAF_CODE));

   assign gp_mode = !env.prot_en || (cpl != 2'd0) || env.v86_mode ||
                    !env.acm_flag || env.in_smm || env.host_root ||
                    (param_reg != '0);

   assign gp_addr = (env.long_mode && !canon_ok) || (target > cs_limit);

   always_comb begin
      if (!env.sec_ext_en)          fault = FLT_UD;
      else if (env.guest_nonroot)   fault = FLT_VMEXIT;
      else if (!leaf_ok)            fault = FLT_UD;
      else if (gp_mode || gp_addr)  fault = FLT_GP;
      else                          fault = FLT_NONE;
   end

endmodule

// File: rtl/secure_exit_steps.sv
module secure_exit_steps #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         launch,
   input  logic [N-1:0] step_ack,
   output logic [N-1:0] step_req,
   output logic         finish
);

   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

   logic [IDX_W-1:0] idx_q;
   logic             issue_q;
   logic             active_q;
   logic [N-1:0]     sel_oh;
   logic             ack_hit;
   logic             last_step;

   generate
      for (genvar g = 0; g < N; g++) begin : g_step
         assign sel_oh[g]   = active_q && (idx_q == IDX_W'(g));
         assign step_req[g] = sel_oh[g] && issue_q;
      end
   endgenerate

   assign ack_hit   = |(sel_oh & step_ack);
   assign last_step = (idx_q == IDX_W'(N-1));
   assign finish    = ack_hit && last_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         issue_q  <= 1'b0;
         active_q <= 1'b0;
      end else if (launch) begin
         idx_q    <= '0;
         issue_q  <= 1'b1;
         active_q <= 1'b1;
      end else if (active_q) begin
         if (ack_hit) begin
            if (last_step) begin
               idx_q    <= '0;
               issue_q  <= 1'b0;
               active_q <= 1'b0;
            end else begin
               idx_q   <= idx_q + IDX_W'(1);
               issue_q <= 1'b1;
            end
         end else begin
            issue_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/secure_exit_seq.sv
module secure_exit_seq
   import secure_exit_pkg::*;
#(
   parameter int unsigned XLEN      = 64,
   parameter int unsigned VA_BITS   = 48,
   parameter int unsigned LEAF_W    = 32,
   parameter int unsigned LEAF_CODE = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                mode_enter,
   input  logic [LEAF_W-1:0]   leaf_sel,
   input  logic                leaf_avail,
   input  logic                sec_ext_en,
   input  logic                guest_nonroot,
   input  logic                host_root,
   input  logic                prot_en,
   input  logic [1:0]          cpl,
   input  logic                v86_mode,
   input  logic                in_smm,
   input  logic                long_mode,
   input  logic [1:0]          op_size,
   input  logic [XLEN-1:0]     param_reg,
   input  logic [XLEN-1:0]     target_reg,
   input  logic [XLEN-1:0]     cs_limit,
   input  logic [N_STEPS-1:0]  step_ack,
   output logic [N_STEPS-1:0]  step_req,
   output logic                busy,
   output logic                done,
   output logic [FLT_W-1:0]    fault,
   output logic                ip_load,
   output logic [XLEN-1:0]     new_ip,
   output logic                acm_active
);

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("secure_exit_seq: XLEN below 32");
      end
      if (VA_BITS < 2 || VA_BITS > XLEN) begin : g_bad_va
         $error("secure_exit_seq: VA_BITS out of range");
      end
      if (LEAF_W < 2) begin : g_bad_leaf
         $error("secure_exit_seq: LEAF_W too narrow");
      end
   endgenerate

   seq_state_e       state_q;
   logic [FLT_W-1:0] pend_flt_q;
   logic [FLT_W-1:0] fault_q;
   logic             done_q;
   logic             ip_load_q;
   logic [XLEN-1:0]  tgt_q;
   logic [XLEN-1:0]  new_ip_q;
   logic             acm_q;

   env_t             env;
   logic [FLT_W-1:0] flt_now;
   logic [XLEN-1:0]  tgt_now;
   logic             launch;
   logic             seq_finish;

   assign env = '{sec_ext_en:    sec_ext_en,
                  guest_nonroot: guest_nonroot,
                  host_root:     host_root,
                  prot_en:       prot_en,
                  v86_mode:      v86_mode,
                  in_smm:        in_smm,
                  long_mode:     long_mode,
                  acm_flag:      acm_q};

   secure_exit_faults #(
      .XLEN      (XLEN),
      .VA_BITS   (VA_BITS),
      .LEAF_W    (LEAF_W),
      .LEAF_CODE (LEAF_CODE)
   ) u_faults (
      .leaf_sel   (leaf_sel),
      .leaf_avail (leaf_avail),
      .env        (env),
      .cpl        (cpl),
      .op_size    (op_size),
      .param_reg  (param_reg),
      .target_reg (target_reg),
      .cs_limit   (cs_limit),
      .fault      (flt_now),
      .target     (tgt_now)
   );

   assign launch = (state_q == ST_IDLE) && start && (flt_now == FLT_NONE);

   secure_exit_steps #(
      .N (N_STEPS)
   ) u_steps (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .step_ack (step_ack),
      .step_req (step_req),
      .finish   (seq_finish)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         pend_flt_q <= FLT_NONE;
         fault_q    <= FLT_NONE;
         done_q     <= 1'b0;
         ip_load_q  <= 1'b0;
         tgt_q      <= '0;
         new_ip_q   <= '0;
         acm_q      <= 1'b0;
      end else begin
         done_q    <= 1'b0;
         ip_load_q <= 1'b0;
         fault_q   <= FLT_NONE;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (flt_now != FLT_NONE) begin
                     state_q    <= ST_REPORT;
                     pend_flt_q <= flt_now;
                  end else begin
                     state_q <= ST_RUN;
                     tgt_q   <= tgt_now;
                  end
               end else if (mode_enter) begin
                  acm_q <= 1'b1;
               end
            end
            ST_REPORT: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
               fault_q <= pend_flt_q;
            end
            ST_RUN: begin
               if (seq_finish) begin
                  state_q   <= ST_IDLE;
                  done_q    <= 1'b1;
                  ip_load_q <= 1'b1;
                  new_ip_q  <= tgt_q;
                  acm_q     <= 1'b0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign fault      = fault_q;
   assign ip_load    = ip_load_q;
   assign new_ip     = new_ip_q;
   assign acm_active = acm_q;

endmodule

// File: rtl/secure_exit_seq_chk.sv
module secure_exit_seq_chk #(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned N_STEPS = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic [2:0]         fault,
   input logic [N_STEPS-1:0] step_req,
   input logic               ip_load,
   input logic [XLEN-1:0]    new_ip,
   input logic               acm_active
);

   localparam int unsigned CW = $clog2(N_STEPS + 1);

   logic [CW-1:0] exp_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                exp_cnt <= '0;
      else if (start && !busy)   exp_cnt <= '0;
      else if (step_req != '0)   exp_cnt <= exp_cnt + CW'(1);
   end

   a_r8_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(step_req));

   a_r8_req_order: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req != '0) |-> (step_req == (N_STEPS'(1) << exp_cnt)));

   a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req != '0) |=> (step_req != $past(step_req)));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (step_req == '0));

   a_r7_fault_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fault));

   a_r7_fault_done: assert property (@(posedge clk) disable iff (!rst_n)
      (fault != 3'b000) |-> (done && !ip_load));

   a_r7_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (fault != 3'b000) |-> $stable(acm_active));

   a_r10_load_clean: assert property (@(posedge clk) disable iff (!rst_n)
      ip_load |-> (done && (fault == 3'b000) && !acm_active));

   a_r10_ip_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ip_load |-> $stable(new_ip));

   a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind secure_exit_seq secure_exit_seq_chk #(
   .XLEN    (XLEN),
   .N_STEPS (secure_exit_pkg::N_STEPS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .fault      (fault),
   .step_req   (step_req),
   .ip_load    (ip_load),
   .new_ip     (new_ip),
   .acm_active (acm_active)
);

// File: tb/secure_exit_seq_tb.sv
`timescale 1ns/1ps
module secure_exit_seq_tb_top;

   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            mode_enter = 1'b0;
   logic [31:0]     leaf_sel;
   logic            leaf_avail;
   logic            sec_ext_en, guest_nonroot, host_root, prot_en;
   logic [1:0]      cpl;
   logic            v86_mode, in_smm, long_mode;
   logic [1:0]      op_size;
   logic [XLEN-1:0] param_reg, target_reg, cs_limit;
   logic [5:0]      step_ack = '0;
   logic [5:0]      step_req;
   logic            busy, done, ip_load, acm_active;
   logic [2:0]      fault;
   logic [XLEN-1:0] new_ip;

   int checks   = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   secure_exit_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_enter(mode_enter),
      .leaf_sel(leaf_sel), .leaf_avail(leaf_avail), .sec_ext_en(sec_ext_en),
      .guest_nonroot(guest_nonroot), .host_root(host_root), .prot_en(prot_en),
      .cpl(cpl), .v86_mode(v86_mode), .in_smm(in_smm), .long_mode(long_mode),
      .op_size(op_size), .param_reg(param_reg), .target_reg(target_reg),
      .cs_limit(cs_limit), .step_ack(step_ack), .step_req(step_req),
      .busy(busy), .done(done), .fault(fault), .ip_load(ip_load),
      .new_ip(new_ip), .acm_active(acm_active)
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic set_clean();
      leaf_sel = 32'd3; leaf_avail = 1'b1; sec_ext_en = 1'b1;
      guest_nonroot = 1'b0; host_root = 1'b0; prot_en = 1'b1; cpl = 2'd0;
      v86_mode = 1'b0; in_smm = 1'b0; long_mode = 1'b1; op_size = 2'b10;
      param_reg = '0; target_reg = 64'h0000_0000_1234_5678; cs_limit = '1;
   endtask

   task automatic enter_mode();
      @(negedge clk) mode_enter = 1'b1;
      @(negedge clk) mode_enter = 1'b0;
      chk(64'(acm_active), 64'd1, "R2 mode_enter sets flag");
   endtask

   task automatic expect_fault(input logic [2:0] exp, input string what);
      logic            acm0;
      logic [XLEN-1:0] ip0;
      @(negedge clk);
      acm0 = acm_active; ip0 = new_ip;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(64'(busy), 64'd1, {what, " R2 busy"});
      chk(64'(step_req), 64'd0, {what, " R7 no strobe"});
      @(negedge clk);
      chk(64'(done), 64'd1, {what, " R7 done"});
      chk(64'(fault), 64'(exp), what);
      chk(64'(busy), 64'd0, {what, " R2 busy low at done"});
      chk(64'(acm_active), 64'(acm0), {what, " R7 flag kept"});
      chk(new_ip, ip0, {what, " R7 ip kept"});
      chk(64'(ip_load), 64'd0, {what, " R7 no load"});
   endtask

   task automatic expect_run(input logic [63:0] exp_ip, input int delay, input string what);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(64'(busy), 64'd1, {what, " R2 busy"});
      for (int i = 0; i < 6; i++) begin
         chk(64'(step_req), 64'(6'(1) << i), {what, " R8 strobe order"});
         for (int d = 0; d < delay; d++) begin
            step_ack = ~(6'(1) << i);
            start    = 1'b1;
            @(negedge clk);
            step_ack = '0;
            start    = 1'b0;
            chk(64'(step_req), 64'd0, {what, " R9 waits for own ack"});
            chk(64'(busy), 64'd1, {what, " R2 start ignored while busy"});
         end
         step_ack = 6'(1) << i;
         @(negedge clk) step_ack = '0;
      end
      chk(64'(done), 64'd1, {what, " R10 done"});
      chk(64'(ip_load), 64'd1, {what, " R10 ip_load"});
      chk(64'(fault), 64'd0, {what, " R10 no fault"});
      chk(new_ip, exp_ip, {what, " R10/R6 new_ip"});
      chk(64'(acm_active), 64'd0, {what, " R10 flag cleared"});
      chk(64'(busy), 64'd0, {what, " R2 idle at done"});
      @(negedge clk);
      chk(64'(done), 64'd0, {what, " R2 single done"});
      chk(64'(busy), 64'd0, {what, " R2 no restart"});
   endtask

   task automatic t_reset();
      chk(64'(busy), 0, "R1 busy");
      chk(64'(done), 0, "R1 done");
      chk(64'(fault), 0, "R1 fault");
      chk(64'(step_req), 0, "R1 step_req");
      chk(64'(ip_load), 0, "R1 ip_load");
      chk(64'(acm_active), 0, "R1 acm_active");
      chk(new_ip, 0, "R1 new_ip");
   endtask

   task automatic t_idle_acks();
      @(negedge clk) step_ack = '1;
      @(negedge clk) step_ack = '0;
      chk(64'(step_req), 0, "R9 ack while idle ignored");
      chk(64'(busy), 0, "R9 idle stays idle");
   endtask

   task automatic t_priority();
      set_clean(); enter_mode();
      sec_ext_en = 1'b0; guest_nonroot = 1'b1; leaf_sel = 32'd2; prot_en = 1'b0;
      expect_fault(3'b001, "R3 ext off wins");
      sec_ext_en = 1'b1;
      expect_fault(3'b100, "R3 guest exit beats leaf");
      guest_nonroot = 1'b0;
      expect_fault(3'b001, "R3 bad leaf beats prot");
      set_clean(); leaf_avail = 1'b0;
      expect_fault(3'b001, "R3 leaf unavailable");
   endtask

   task automatic t_gp_each();
      set_clean(); prot_en = 1'b0;    expect_fault(3'b010, "R4 prot off");
      set_clean(); cpl = 2'd3;        expect_fault(3'b010, "R4 cpl");
      set_clean(); v86_mode = 1'b1;   expect_fault(3'b010, "R4 v86");
      set_clean(); in_smm = 1'b1;     expect_fault(3'b010, "R4 smm");
      set_clean(); host_root = 1'b1;  expect_fault(3'b010, "R4 host root");
      set_clean(); param_reg = 64'h8; expect_fault(3'b010, "R4 param nonzero");
      set_clean(); target_reg = 64'h0000_8000_0000_0000;
      expect_fault(3'b010, "R5 noncanonical");
      set_clean(); op_size = 2'b01; target_reg = 64'h2000; cs_limit = 64'h1FFF;
      expect_fault(3'b010, "R6 above limit");
   endtask

   initial begin
      set_clean();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_acks();
      // flag clear -> protection fault
      set_clean();
      expect_fault(3'b010, "R4 mode flag clear");
      t_priority();
      t_gp_each();
      // 64-bit success, canonical upper target, immediate acks
      set_clean(); target_reg = 64'h0000_7FFF_0000_1000;
      expect_run(64'h0000_7FFF_0000_1000, 0, "R8 op64");
      // flag now cleared
      expect_fault(3'b010, "R10 flag clear after exit");
      // 32-bit truncation, delayed acks, noise
      set_clean(); enter_mode(); long_mode = 1'b0; op_size = 2'b01;
      target_reg = 64'hFFFF_FFFF_8765_4321;
      expect_run(64'h0000_0000_8765_4321, 2, "R6 op32");
      // 16-bit truncation
      set_clean(); enter_mode(); long_mode = 1'b0; op_size = 2'b00;
      target_reg = 64'hABCD_1234_5678_9ABC;
      expect_run(64'h0000_0000_0000_9ABC, 1, "R6 op16");
      // no canonical check outside 64-bit mode
      set_clean(); enter_mode(); long_mode = 1'b0;
      target_reg = 64'h0000_8000_0000_0000;
      expect_run(64'h0000_8000_0000_0000, 0, "R5 no canon check");
      // limit boundary: equal passes
      set_clean(); enter_mode(); op_size = 2'b01;
      target_reg = 64'h2000; cs_limit = 64'h2000;
      expect_run(64'h2000, 0, "R6 at limit");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule